// File: doc/BRIEF.md
# Four-Tap Shift-Chain FIR Filter

This block is a four-tap finite impulse response filter built around a multiply-add tree. Signed samples enter a register shift chain on every rising edge of the main clock. Each tap is multiplied by its own signed coefficient, and the four products are summed into a registered output that is wide enough never to overflow.

The coefficients arrive on their own port and clock. They are written in parallel into a holding bank whenever the write enable is high at a coefficient-clock edge. A toggle, passed through a synchronizer, tells the main-clock domain to copy the bank into the working coefficients. Coefficients are expected to change rarely, and the holding bank must stay still while a transfer is in flight.

A 40-bit accumulator can follow the filter output, either loading the newest sum or adding it to its running total. Its load control can pass straight through or go through a pipeline register. That register has a build-time choice of asynchronous clear: none, the main reset, or a separate clear input.

Top module: `fir4_mac_filter`

## Requirements
- R1: `sum_o` is the exact signed sum of the four products of 16-bit signed tap samples and 16-bit signed coefficients, held in 34 bits with no overflow. All four taps and all four coefficients at -32768 give +4294967296.
- R2: The sample on `sample_i` is captured into tap 0 on every `clk_i` rising edge, and every other tap takes the previous contents of the tap before it. Coefficient i sits in `coef_i` bits [16i+15:16i] and multiplies the sample captured i edges before the newest one. A sample captured at edge k first appears in `sum_o` after edge k+1.
- R3: At a `cclk_i` rising edge with `coef_we_i` low, the value on `coef_i` is ignored, and the coefficients already in use stay in effect.
- R4: At a `cclk_i` rising edge with `coef_we_i` high, all four coefficients are captured at once. They reach `sum_o` within six `clk_i` edges and replace all four old values together.
- R5: `valid_o` is low after reset. It rises after the fifth `clk_i` edge since reset, which is the first sum built from four captured samples, and it then stays high until the next reset.
- R6: While `rst_ni` is low, the taps, `sum_o`, `acc_o` and `valid_o` read zero. Coefficients loaded through `cclk_i` are still in effect after `rst_ni` is released.
- R7: At an edge with `acc_en_i` high, the accumulator loads the new sum if the effective load is high, and otherwise adds the new sum to its total. With `acc_en_i` low, `acc_o` holds its value.
- R8: With `LOAD_PIPE`=0 (the default), `acc_load_i` acts at the edge that samples it. With `LOAD_PIPE`=1, it acts one `clk_i` edge later.
- R9: `LOAD_CLR` selects the asynchronous clear of the load pipeline register. NONE (the default) has no clear, MAIN uses `rst_ni`, and AUX uses `aux_clr_ni`. A clear pulse between edges cancels a load that was already captured in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock for the sample chain, products, output and accumulator |
| rst_ni | input | 1 | Active-low asynchronous reset for the main-clock domain |
| cclk_i | input | 1 | Coefficient write clock |
| crst_ni | input | 1 | Active-low asynchronous reset for the coefficient holding bank |
| aux_clr_ni | input | 1 | Active-low asynchronous clear for the load pipeline register when AUX is selected |
| sample_i | input | 16 | Signed input sample |
| coef_i | input | 64 | Four signed coefficients, coefficient i in bits [16i+15:16i] |
| coef_we_i | input | 1 | Coefficient write enable, sampled on `cclk_i` |
| acc_en_i | input | 1 | Accumulator update enable |
| acc_load_i | input | 1 | Accumulator load request (replace the total instead of adding) |
| sum_o | output | 34 | Registered signed filter output |
| acc_o | output | 40 | Signed accumulator total |
| valid_o | output | 1 | High once `sum_o` covers four captured samples |

## Verification
A stuck or misrouted tap shows up in `sum_o` one edge after an impulse reaches it, because each coefficient then appears on its own in sequence. A transfer that copies the wrong bank, or that misses its toggle, leaves the old coefficients in the impulse response six edges after the load. The same happens for a write that should have been ignored. A wrong load timing or a missed clear of the load pipe changes `acc_o` at the very next edge, and from then on every later total differs from the total the bench builds from the sums.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  typedef enum logic [1:0] {
    LCLR_NONE = 2'd0,
    LCLR_MAIN = 2'd1,
    LCLR_AUX  = 2'd2
  } load_clr_e;

  function automatic int sum_width(input int sample_w, input int coef_w, input int taps);
    return sample_w + coef_w + $clog2(taps);
  endfunction

endpackage

// File: rtl/fir4_tap_chain.sv
module fir4_tap_chain #(
  parameter int TAPS     = 4,
  parameter int SAMPLE_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [SAMPLE_W-1:0]            sample_i,
  output logic [TAPS-1:0][SAMPLE_W-1:0]  taps_o,
  output logic                           full_o
);

  localparam int CNT_W = $clog2(TAPS + 1);
  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(TAPS);

  logic [CNT_W-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taps_o <= '0;
      fill_q <= '0;
    end else begin
      taps_o <= {taps_o[TAPS-2:0], sample_i};
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end

  assign full_o = (fill_q == FILL_MAX);

  for (genvar i = 1; i < TAPS; i++) begin : g_shift_chk
    p_chain_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      taps_o[i] == $past(taps_o[i-1]));
  end

  p_full_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> full_o);

endmodule

// File: rtl/fir4_coef_xfer.sv
module fir4_coef_xfer #(
  parameter int TAPS   = 4,
  parameter int COEF_W = 16
) (
  input  logic                          cclk_i,
  input  logic                          crst_ni,
  input  logic [TAPS*COEF_W-1:0]        coef_i,
  input  logic                          coef_we_i,
  input  logic                          clk_i,
  input  logic                          rst_ni,
  output logic [TAPS-1:0][COEF_W-1:0]   coef_o
);

  localparam int SYNC_N = 3;

  logic [TAPS-1:0][COEF_W-1:0] bank_q;
  logic                        tgl_q;
  logic [SYNC_N-1:0]           sync_q;
  logic                        xfer_go;

  // coefficient-clock side: parallel capture, toggle marks a new bank
  always_ff @(posedge cclk_i or negedge crst_ni) begin
    if (!crst_ni) begin
      bank_q <= '0;
      tgl_q  <= 1'b0;
    end else if (coef_we_i) begin
      bank_q <= coef_i;
      tgl_q  <= ~tgl_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_N-2:0], tgl_q};
  end

  assign xfer_go = sync_q[SYNC_N-1] ^ sync_q[SYNC_N-2];

  // working copy survives main reset; bank is quasi-static during transfer
  always_ff @(posedge clk_i) begin
    if (xfer_go) coef_o <= bank_q;
  end

  p_coef_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_go |=> $stable(coef_o));

endmodule

// File: rtl/fir4_mac_tree.sv
module fir4_mac_tree #(
  parameter int TAPS     = 4,
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int SUM_W    = 34
) (
  input  logic [TAPS-1:0][SAMPLE_W-1:0] taps_i,
  input  logic [TAPS-1:0][COEF_W-1:0]   coefs_i,
  output logic signed [SUM_W-1:0]       sum_o
);

  localparam int PROD_W = SAMPLE_W + COEF_W;

  logic signed [PROD_W-1:0] prod [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : g_prod
    assign prod[i] = $signed(taps_i[i]) * $signed(coefs_i[i]);
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < TAPS; i++) sum_o = sum_o + SUM_W'(prod[i]);
  end

endmodule

// File: rtl/fir4_accum.sv
module fir4_accum
  import fir4_pkg::*;
#(
  parameter int        SUM_W     = 34,
  parameter int        ACC_W     = 40,
  parameter bit        LOAD_PIPE = 1'b0,
  parameter load_clr_e LOAD_CLR  = LCLR_NONE
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    aux_clr_ni,
  input  logic                    en_i,
  input  logic                    load_i,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic signed [ACC_W-1:0] acc_o
);

  logic load_q;
  logic load_eff;
  logic pipe_clr_n;

  assign pipe_clr_n = (LOAD_CLR == LCLR_AUX)  ? aux_clr_ni :
                      (LOAD_CLR == LCLR_MAIN) ? rst_ni     : 1'b1;

  always_ff @(posedge clk_i or negedge pipe_clr_n) begin
    if (!pipe_clr_n) load_q <= 1'b0;
    else             load_q <= load_i;
  end

  assign load_eff = LOAD_PIPE ? load_q : load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_o <= '0;
    else if (en_i) begin
      if (load_eff)    acc_o <= ACC_W'(sum_i);
      else             acc_o <= acc_o + ACC_W'(sum_i);
    end
  end

  p_acc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_o));

endmodule

// File: rtl/fir4_mac_filter.sv
module fir4_mac_filter
  import fir4_pkg::*;
#(
  parameter int        TAPS      = 4,
  parameter int        SAMPLE_W  = 16,
  parameter int        COEF_W    = 16,
  parameter int        ACC_W     = 40,
  parameter bit        LOAD_PIPE = 1'b0,
  parameter load_clr_e LOAD_CLR  = LCLR_NONE,
  localparam int       SUM_W     = sum_width(SAMPLE_W, COEF_W, TAPS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cclk_i,
  input  logic                    crst_ni,
  input  logic                    aux_clr_ni,
  input  logic [SAMPLE_W-1:0]     sample_i,
  input  logic [TAPS*COEF_W-1:0]  coef_i,
  input  logic                    coef_we_i,
  input  logic                    acc_en_i,
  input  logic                    acc_load_i,
  output logic [SUM_W-1:0]        sum_o,
  output logic [ACC_W-1:0]        acc_o,
  output logic                    valid_o
);

  logic [TAPS-1:0][SAMPLE_W-1:0] taps;
  logic [TAPS-1:0][COEF_W-1:0]   coefs;
  logic                          full;
  logic signed [SUM_W-1:0]       tree_sum;
  logic signed [SUM_W-1:0]       sum_q;
  logic signed [ACC_W-1:0]       acc;

  fir4_tap_chain #(.TAPS(TAPS), .SAMPLE_W(SAMPLE_W)) i_chain (
    .clk_i, .rst_ni, .sample_i, .taps_o(taps), .full_o(full)
  );

  fir4_coef_xfer #(.TAPS(TAPS), .COEF_W(COEF_W)) i_xfer (
    .cclk_i, .crst_ni, .coef_i, .coef_we_i, .clk_i, .rst_ni, .coef_o(coefs)
  );

  fir4_mac_tree #(.TAPS(TAPS), .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .SUM_W(SUM_W)) i_tree (
    .taps_i(taps), .coefs_i(coefs), .sum_o(tree_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      sum_q   <= tree_sum;
      valid_o <= full;
    end
  end

  fir4_accum #(.SUM_W(SUM_W), .ACC_W(ACC_W), .LOAD_PIPE(LOAD_PIPE), .LOAD_CLR(LOAD_CLR)) i_acc (
    .clk_i, .rst_ni, .aux_clr_ni, .en_i(acc_en_i), .load_i(acc_load_i),
    .sum_i(tree_sum), .acc_o(acc)
  );

  assign sum_o = sum_q;
  assign acc_o = acc;

  p_valid_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  p_valid_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> full);

  if (!LOAD_PIPE) begin : g_direct_load_chk
    p_acc_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_en_i && acc_load_i) |=> $signed(acc_o) == ACC_W'($signed(sum_o)));
  end

endmodule

// File: tb/test_fir4_mac_filter.sv
module test_fir4_mac_filter;
  import fir4_pkg::*;

  logic        clk = 1'b0;
  logic        cclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crst_n = 1'b0;
  logic        aux_clr_n = 1'b1;
  logic [15:0] sample = '0;
  logic [63:0] coef = '0;
  logic        coef_we = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_ld = 1'b0;
  logic [33:0] sum_a, sum_b;
  logic [39:0] acc_a, acc_b;
  logic        valid_a, valid_b;

  int     n_chk = 0;
  int     n_fail = 0;
  int     nedge = 0;
  longint mt [4];
  longint mc [4];
  longint exp_sum = 0, exp_acc = 0, exp_accp = 0;
  bit     ldq = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;
  always #5 cclk = ~cclk;

  always @(posedge clk) begin
    if (!rst_n) nedge <= 0;
    else        nedge <= nedge + 1;
  end

  fir4_mac_filter i_fir4_mac_filter (
    .clk_i(clk), .rst_ni(rst_n), .cclk_i(cclk), .crst_ni(crst_n), .aux_clr_ni(aux_clr_n),
    .sample_i(sample), .coef_i(coef), .coef_we_i(coef_we), .acc_en_i(acc_en),
    .acc_load_i(acc_ld), .sum_o(sum_a), .acc_o(acc_a), .valid_o(valid_a)
  );

  fir4_mac_filter #(.LOAD_PIPE(1'b1), .LOAD_CLR(LCLR_AUX)) i_fir4_mac_filter_piped (
    .clk_i(clk), .rst_ni(rst_n), .cclk_i(cclk), .crst_ni(crst_n), .aux_clr_ni(aux_clr_n),
    .sample_i(sample), .coef_i(coef), .coef_we_i(coef_we), .acc_en_i(acc_en),
    .acc_load_i(acc_ld), .sum_o(sum_b), .acc_o(acc_b), .valid_o(valid_b)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic longint dot();
    longint s = 0;
    for (int i = 0; i < 4; i++) s += mc[i] * mt[i];
    return s;
  endfunction

  // one main-clock cycle: check outputs, then drive next inputs and advance the model
  task automatic tick(input int x, input bit en, input bit ld, input bit chk,
                      input bit clrp, input string tag);
    longint d, sa, sb, aa, ab;
    @(negedge clk);
    if (chk) begin
      sa = longint'($signed(sum_a));
      sb = longint'($signed(sum_b));
      aa = longint'($signed(acc_a));
      ab = longint'($signed(acc_b));
      check(sa == exp_sum, tag, "sum_o", sa, exp_sum);
      check(sb == exp_sum, tag, "sum_o piped", sb, exp_sum);
      check(aa == exp_acc, tag, "acc_o", aa, exp_acc);
      check(ab == exp_accp, tag, "acc_o piped", ab, exp_accp);
      check(valid_a == (nedge >= 5), "R5", "valid_o", longint'(valid_a), longint'(nedge >= 5));
    end
    if (clrp) begin
      aux_clr_n = 1'b0;
      #1;
      aux_clr_n = 1'b1;
      ldq = 1'b0;
    end
    d = dot();
    if (en) exp_acc  = ld  ? d : exp_acc + d;
    if (en) exp_accp = ldq ? d : exp_accp + d;
    ldq     = ld;
    exp_sum = d;
    sample  = 16'(x);
    acc_en  = en;
    acc_ld  = ld;
    for (int i = 3; i > 0; i--) mt[i] = mt[i-1];
    mt[0] = longint'($signed(16'(x)));
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) tick(0, 1'b0, 1'b0, 1'b0, 1'b0, "flush");
  endtask

  function automatic int next_sample();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15]));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sample = '0; acc_en = 1'b0; acc_ld = 1'b0;
    repeat (3) @(negedge clk);
    check(sum_a == '0, "R6", "sum_o in reset", longint'($signed(sum_a)), 0);
    check(acc_a == '0, "R6", "acc_o in reset", longint'($signed(acc_a)), 0);
    check(acc_b == '0, "R6", "acc_o piped in reset", longint'($signed(acc_b)), 0);
    check(valid_a == 1'b0, "R6", "valid_o in reset", longint'(valid_a), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) mt[i] = 0;
    exp_sum = 0; exp_acc = 0; exp_accp = 0; ldq = 1'b0;
  endtask

  task automatic write_coef(input int c0, input int c1, input int c2, input int c3,
                            input bit we);
    flush(4);
    @(negedge cclk);
    coef = {16'(c3), 16'(c2), 16'(c1), 16'(c0)};
    coef_we = we;
    @(negedge cclk);
    coef_we = 1'b0;
    if (we) begin
      mc[0] = c0; mc[1] = c1; mc[2] = c2; mc[3] = c3;
    end
  endtask

  task automatic impulse(input int amp, input string tag);
    tick(amp, 1'b0, 1'b0, 1'b1, 1'b0, tag);
    for (int i = 0; i < 6; i++) tick(0, 1'b0, 1'b0, 1'b1, 1'b0, tag);
  endtask

  // R2 R5: single nonzero sample walks past each coefficient in order
  task automatic t_impulse();
    write_coef(3, -5, 7, 11, 1'b1);
    flush(6);
    impulse(1, "R2");
    impulse(-2, "R2");
  endtask

  // R1: pseudo-random signed samples against the model sum
  task automatic t_random();
    for (int i = 0; i < 24; i++) tick(next_sample(), 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    flush(4);
  endtask

  // R1: extreme negative operands, largest positive sum
  task automatic t_fullscale();
    write_coef(-32768, -32768, -32768, -32768, 1'b1);
    flush(6);
    for (int i = 0; i < 6; i++) tick(-32768, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    check(longint'($signed(sum_a)) == 64'sd4294967296, "R1", "full-scale sum",
          longint'($signed(sum_a)), 64'sd4294967296);
    for (int i = 0; i < 6; i++) tick(32767, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    flush(4);
  endtask

  // R3: writes with enable low leave coefficients untouched
  task automatic t_coef_ignore();
    write_coef(3, -5, 7, 11, 1'b1);
    flush(6);
    write_coef(100, 200, 300, 400, 1'b0);
    repeat (3) @(negedge cclk);
    flush(6);
    impulse(5, "R3");
  endtask

  // R4: new bank reaches the sum within six main-clock edges
  task automatic t_coef_update();
    write_coef(-9, 4, 0, 21, 1'b1);
    flush(6);
    impulse(3, "R4");
    write_coef(3, -5, 7, 11, 1'b1);
    flush(6);
    impulse(1, "R4");
  endtask

  // R7: load, accumulate, hold
  task automatic t_accum();
    tick(next_sample() / 8, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 6; i++) tick(next_sample() / 8, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 3; i++) tick(next_sample() / 8, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    tick(next_sample() / 8, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 4; i++) tick(next_sample() / 8, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
  endtask

  // R8: isolated load pulses show the one-edge lag in the piped build
  task automatic t_pipe();
    for (int k = 0; k < 3; k++) begin
      tick(next_sample() / 8, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
      for (int i = 0; i < 3; i++) tick(next_sample() / 8, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
    end
  endtask

  // R9: clear pulse drops a load already held in the pipeline register
  task automatic t_pipe_clear();
    for (int i = 0; i < 3; i++) tick(next_sample() / 8, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
    tick(next_sample() / 8, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
    tick(next_sample() / 8, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 4; i++) tick(next_sample() / 8, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
  endtask

  // R6: reset mid-stream, coefficients still in effect afterwards
  task automatic t_midreset();
    for (int i = 0; i < 5; i++) tick(next_sample(), 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    do_reset();
    impulse(7, "R6");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mt[i] = 0; mc[i] = 0; end
    #7 crst_n = 1'b1;
    do_reset();
    flush(2);
    t_impulse();
    t_random();
    t_fullscale();
    t_coef_ignore();
    t_coef_update();
    t_accum();
    t_pipe();
    t_pipe_clear();
    t_midreset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule